// File: doc/BRIEF.md
# Configurable duplex UART

This block is a single-channel asynchronous serial port that sends and receives at the same time. Software-side logic writes one character into a one-entry transmit holding register and reads received characters from a one-entry receive holding register. The frame format is set at run time through mode inputs. The character length is 5 to 8 bits. Parity is off, even or odd. The transmitter sends one or two stop bits. The line polarity can be inverted, and the data bits can go out least- or most-significant first. Transmitter and receiver always use the same format.

A shared baud generator divides the system clock by a programmable divisor. It produces a tick at sixteen times the bit rate, and both directions count these ticks. The receiver brings the line in through a synchroniser and waits for a falling edge. It confirms the start bit at mid-bit and samples every later bit at its centre. It raises sticky error flags for a parity mismatch, a missing stop bit and a lost character. Each finished character, in either direction, gives a one-cycle interrupt pulse. A two-bit block-disable control holds the whole port in reset.

Top module: `duplex_uart`

## Requirements
- R1: `len_sel` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits per character on both transmit and receive. Bits of `rx_data` above the selected length read as 0.
- R2: With `par_en`=0 no parity bit is sent or expected. With `par_en`=1 one parity bit follows the data bits. With `par_odd`=0 it makes the count of ones in data plus parity even; with `par_odd`=1 it makes that count odd.
- R3: With `stop2`=1 the transmitter sends two stop bits, otherwise one. The receiver checks only the first stop bit, so a start bit may follow one stop bit directly.
- R4: A received parity bit that does not match sets `err_parity`. The character is still delivered to `rx_data`.
- R5: A first stop bit sampled as 0 sets `err_frame`.
- R6: A character that completes while `rx_valid` is still 1 and no `rx_rd` is given in that cycle sets `err_overrun`. The new character replaces the old one in `rx_data`.
- R7: `tx_busy` goes to 1 in the cycle after a `tx_wr` strobe. It falls when the held character moves into the shift register. It stays at 1 while a second character waits behind a frame in progress.
- R8: With `invert`=0 the idle `txd` level is 1. With `invert`=1 every transmitted level is inverted, the idle level included. The `rxd` input is interpreted with the same inversion.
- R9: `msb_first` reverses only the order of the data bits. The start bit, the parity bit and the stop bits stay where they are.
- R10: One bit lasts 16 × (`divisor` + 1) clock cycles. A frame starts on a baud tick, so a start bit is exactly this long.
- R11: With `blk_off` = 2'b11 the whole port is held in reset: holding registers empty, flags clear, `txd` at idle. Any other `blk_off` value with a nonzero bit stops the baud ticks but clears no state.
- R12: A start bit that is no longer low at its midpoint is discarded. No character and no `rx_int` follow from it.
- R13: `rx_int` pulses for one cycle per received character, and `tx_int` pulses for one cycle at the end of each transmitted frame. Error flags stay set until `err_clr`. `rx_rd` clears `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_off | input | 2 | Block-disable pair; 2'b11 holds the port in reset |
| divisor | input | DIV_W | Baud divisor; tick every divisor+1 clocks |
| len_sel | input | 2 | Data length code (0..3 → 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| stop2 | input | 1 | Two transmit stop bits |
| invert | input | 1 | Negative line logic on txd and rxd |
| msb_first | input | 1 | Data bits most-significant first |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Character to transmit |
| rx_rd | input | 1 | Read strobe, clears rx_valid |
| err_clr | input | 1 | Clears the three error flags |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_busy | output | 1 | Transmit holding register occupied |
| tx_int | output | 1 | One-cycle pulse at end of a transmitted frame |
| rx_data | output | 8 | Last received character, zero-extended |
| rx_valid | output | 1 | Receive holding register holds an unread character |
| rx_int | output | 1 | One-cycle pulse per received character |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
The bench keeps the default parameters (a 16-bit divisor field and 16 samples per bit). It runs most scenarios with a divisor of 0, so a bit lasts 16 clocks and a full frame in any of the tested formats finishes in under 200 cycles. Short frames let it cover all four lengths, both parities, both bit orders and both polarities in loopback, and drive hand-built faulty frames into the receiver. One scenario raises the divisor to 2 to show that the bit time scales with the divisor and lands exactly on tick boundaries.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;
  localparam int CHAR_MAX = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } line_state_e;

  // Mask of the data bits in use for a length code (0..3 -> 5..8 bits).
  function automatic logic [CHAR_MAX-1:0] len_mask(input logic [1:0] sel);
    return {CHAR_MAX{1'b1}} >> (2'd3 - sel);
  endfunction

  // Index of the last data bit for a length code.
  function automatic logic [2:0] last_idx(input logic [1:0] sel);
    return 3'd4 + {1'b0, sel};
  endfunction
endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (!en) begin
      tick <= 1'b0;
    end else if (cnt_q >= div) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_unit.sv
module uart_tx_unit
  import uart_cfg_pkg::*;
#(
  parameter int OVS = 16,
  localparam int SUB_W = $clog2(OVS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [1:0]          len_sel,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                stop2,
  input  logic                invert,
  input  logic                msb_first,
  input  logic                wr,
  input  logic [CHAR_MAX-1:0] wr_data,
  output logic                txd,
  output logic                busy,
  output logic                done_int
);
  line_state_e         st_q;
  logic [SUB_W-1:0]    sub_q;
  logic [2:0]          idx_q;
  logic                stop_q;
  logic [CHAR_MAX-1:0] buf_q, shf_q;
  logic                full_q, txd_q, int_q;
  logic [2:0]          last, sel;
  logic                sub_end, par_bit, level;

  assign last    = last_idx(len_sel);
  assign sel     = msb_first ? (last - idx_q) : idx_q;
  assign sub_end = (sub_q == SUB_W'(OVS - 1));
  assign par_bit = (^(shf_q & len_mask(len_sel))) ^ par_odd;

  always_comb begin
    case (st_q)
      ST_START: level = 1'b0;
      ST_DATA:  level = shf_q[sel];
      ST_PAR:   level = par_bit;
      default:  level = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      sub_q  <= '0;
      idx_q  <= '0;
      stop_q <= 1'b0;
      buf_q  <= '0;
      shf_q  <= '0;
      full_q <= 1'b0;
      txd_q  <= ~invert;
      int_q  <= 1'b0;
    end else begin
      int_q <= 1'b0;
      txd_q <= level ^ invert;
      if (tick) begin
        if (st_q == ST_IDLE) begin
          if (full_q) begin
            shf_q  <= buf_q;
            full_q <= 1'b0;
            st_q   <= ST_START;
            sub_q  <= '0;
          end
        end else if (!sub_end) begin
          sub_q <= sub_q + 1'b1;
        end else begin
          sub_q <= '0;
          case (st_q)
            ST_START: begin
              st_q  <= ST_DATA;
              idx_q <= '0;
            end
            ST_DATA: begin
              if (idx_q == last) begin
                st_q   <= par_en ? ST_PAR : ST_STOP;
                stop_q <= 1'b0;
              end else begin
                idx_q <= idx_q + 3'd1;
              end
            end
            ST_PAR: begin
              st_q   <= ST_STOP;
              stop_q <= 1'b0;
            end
            default: begin
              if (stop2 && !stop_q) begin
                stop_q <= 1'b1;
              end else begin
                int_q <= 1'b1;
                if (full_q) begin
                  shf_q  <= buf_q;
                  full_q <= 1'b0;
                  st_q   <= ST_START;
                end else begin
                  st_q <= ST_IDLE;
                end
              end
            end
          endcase
        end
      end
      if (wr) begin
        buf_q  <= wr_data;
        full_q <= 1'b1;
      end
    end
  end

  assign txd      = txd_q;
  assign busy     = full_q;
  assign done_int = int_q;

  assert_busy_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr |=> busy);

  // R8: an idle transmitter with a steady polarity shows the idle level.
  assert_idle_level_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE && $stable(invert)) |-> (txd == ~invert));
endmodule

// File: rtl/uart_rx_unit.sv
module uart_rx_unit
  import uart_cfg_pkg::*;
#(
  parameter int OVS = 16,
  localparam int SUB_W = $clog2(OVS),
  localparam int HALF = OVS / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                rxd,
  input  logic [1:0]          len_sel,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                invert,
  input  logic                msb_first,
  input  logic                rd,
  input  logic                err_clr,
  output logic [CHAR_MAX-1:0] data,
  output logic                valid,
  output logic                done_int,
  output logic                perr,
  output logic                ferr,
  output logic                oerr
);
  logic                s1_q, s2_q, s3_q;
  line_state_e         st_q;
  logic [SUB_W-1:0]    sub_q;
  logic [2:0]          idx_q;
  logic [CHAR_MAX-1:0] shf_q, data_q;
  logic                acc_q, pend_q, valid_q, int_q, perr_q, ferr_q, oerr_q;
  logic [2:0]          last, pos;
  logic                sub_end, mid_start, finish;

  assign last      = last_idx(len_sel);
  assign pos       = msb_first ? (last - idx_q) : idx_q;
  assign sub_end   = (sub_q == SUB_W'(OVS - 1));
  assign mid_start = (sub_q == SUB_W'(HALF - 1));
  assign finish    = tick && sub_end && (st_q == ST_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b1; s2_q <= 1'b1; s3_q <= 1'b1;
      st_q <= ST_IDLE;
      sub_q <= '0; idx_q <= '0;
      shf_q <= '0; data_q <= '0;
      acc_q <= 1'b0; pend_q <= 1'b0;
      valid_q <= 1'b0; int_q <= 1'b0;
      perr_q <= 1'b0; ferr_q <= 1'b0; oerr_q <= 1'b0;
    end else begin
      s1_q  <= rxd ^ invert;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      int_q <= 1'b0;
      if (rd) valid_q <= 1'b0;
      if (err_clr) begin
        perr_q <= 1'b0; ferr_q <= 1'b0; oerr_q <= 1'b0;
      end
      case (st_q)
        ST_IDLE: begin
          if (s3_q && !s2_q) begin
            st_q  <= ST_START;
            sub_q <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (mid_start) begin
              if (!s2_q) begin
                st_q <= ST_DATA;
                sub_q <= '0; idx_q <= '0; shf_q <= '0;
                acc_q <= 1'b0; pend_q <= 1'b0;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (!sub_end) begin
              sub_q <= sub_q + 1'b1;
            end else begin
              sub_q <= '0;
              case (st_q)
                ST_DATA: begin
                  shf_q[pos] <= s2_q;
                  acc_q      <= acc_q ^ s2_q;
                  if (idx_q == last) st_q <= par_en ? ST_PAR : ST_STOP;
                  else idx_q <= idx_q + 3'd1;
                end
                ST_PAR: begin
                  pend_q <= acc_q ^ s2_q ^ par_odd;
                  st_q   <= ST_STOP;
                end
                default: begin
                  data_q  <= shf_q;
                  valid_q <= 1'b1;
                  int_q   <= 1'b1;
                  if (!s2_q) ferr_q <= 1'b1;
                  if (pend_q) perr_q <= 1'b1;
                  if (valid_q && !rd) oerr_q <= 1'b1;
                  st_q <= ST_IDLE;
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  assign data     = data_q;
  assign valid    = valid_q;
  assign done_int = int_q;
  assign perr     = perr_q;
  assign ferr     = ferr_q;
  assign oerr     = oerr_q;

  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (rst)
    (finish && valid_q && !rd) |=> oerr_q);

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    int_q |-> ((data_q & ~len_mask(len_sel)) == '0));

  assert_frame_err_at_stop_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ferr_q) |-> $past(st_q == ST_STOP));

  assert_start_reject_R12: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_START && tick && mid_start && s2_q) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/duplex_uart.sv
module duplex_uart #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       blk_off,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       len_sel,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             stop2,
  input  logic             invert,
  input  logic             msb_first,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  input  logic             rx_rd,
  input  logic             err_clr,
  input  logic             rxd,
  output logic             txd,
  output logic             tx_busy,
  output logic             tx_int,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_int,
  output logic             err_parity,
  output logic             err_frame,
  output logic             err_overrun
);
  logic core_rst, run, tick;

  assign core_rst = rst | (&blk_off);
  assign run      = (blk_off == 2'b00);

  baud_tick_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(core_rst), .en(run), .div(divisor), .tick(tick)
  );

  uart_tx_unit #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(core_rst), .tick(tick),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
    .invert(invert), .msb_first(msb_first),
    .wr(tx_wr), .wr_data(tx_data),
    .txd(txd), .busy(tx_busy), .done_int(tx_int)
  );

  uart_rx_unit #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(core_rst), .tick(tick), .rxd(rxd),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
    .invert(invert), .msb_first(msb_first),
    .rd(rx_rd), .err_clr(err_clr),
    .data(rx_data), .valid(rx_valid), .done_int(rx_int),
    .perr(err_parity), .ferr(err_frame), .oerr(err_overrun)
  );

  assert_block_reset_R11: assert property (@(posedge clk) disable iff (rst)
    (&blk_off) |=> (!rx_valid && !tx_busy && !err_overrun));
endmodule

// File: tb/test_duplex_uart.sv
module test_duplex_uart;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  blk_off = 2'b00;
  logic [15:0] divisor = 16'd0;
  logic [1:0]  len_sel = 2'd3;
  logic        par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, invert = 1'b0, msb_first = 1'b0;
  logic        tx_wr = 1'b0, rx_rd = 1'b0, err_clr = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        loop = 1'b1, drv = 1'b1;
  logic        rxd, txd, tx_busy, tx_int, rx_valid, rx_int;
  logic        err_parity, err_frame, err_overrun;
  logic [7:0]  rx_data;

  int checks = 0, errors = 0;
  int cyc_n = 0, n_tx = 0, n_rx = 0, tx_last = 0, tx_prev = 0;
  bit done = 0;

  assign rxd = loop ? txd : drv;

  always #5 clk = ~clk;

  duplex_uart i_duplex_uart (
    .clk(clk), .rst(rst), .blk_off(blk_off), .divisor(divisor),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
    .invert(invert), .msb_first(msb_first),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .err_clr(err_clr),
    .rxd(rxd), .txd(txd), .tx_busy(tx_busy), .tx_int(tx_int),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_int(rx_int),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
  );

  always @(negedge clk) begin
    cyc_n++;
    if (tx_int) begin n_tx++; tx_prev = tx_last; tx_last = cyc_n; end
    if (rx_int) n_rx++;
  end

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic pe, po, s2, inv, msb);
    len_sel = l; par_en = pe; par_odd = po; stop2 = s2; invert = inv; msb_first = msb;
    drv = ~inv;
    cyc(40);
  endtask

  task automatic write_tx(input logic [7:0] d);
    tx_wr = 1'b1; tx_data = d; cyc(1); tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    rx_rd = 1'b1; cyc(1); rx_rd = 1'b0;
  endtask

  task automatic clear_err();
    err_clr = 1'b1; cyc(1); err_clr = 1'b0;
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d, input int len,
                                             input logic pe, input logic po, input logic msb);
    logic [11:0] f;
    logic p;
    int k;
    f = '1; f[0] = 1'b0; p = po;
    for (int i = 0; i < len; i++) begin
      k = msb ? (len - 1 - i) : i;
      f[1 + i] = d[k];
      p = p ^ d[k];
    end
    k = 1 + len;
    if (pe) begin f[k] = p; k++; end
    f[k] = 1'b1;
    return f;
  endfunction

  task automatic capture(input int n, output logic [11:0] got);
    int w;
    got = '1; w = 0;
    while ((txd ^ invert) != 1'b0 && w < 400) begin cyc(1); w++; end
    cyc(8);
    got[0] = txd ^ invert;
    for (int i = 1; i < n; i++) begin
      cyc(16);
      got[i] = txd ^ invert;
    end
  endtask

  task automatic drive_rx(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      drv = bits[i] ^ invert;
      cyc(16);
    end
    drv = ~invert;
  endtask

  task automatic t_reset();
    cyc(2);
    check(txd == 1'b1, "R8 reset idle line", int'(txd), 1);
    check(tx_busy == 1'b0, "R7 reset busy", int'(tx_busy), 0);
    check(rx_valid == 1'b0, "R13 reset rx_valid", int'(rx_valid), 0);
    check({err_parity, err_frame, err_overrun} == 3'b000, "R4 R5 R6 reset flags",
          int'({err_parity, err_frame, err_overrun}), 0);
  endtask

  task automatic t_frame(input logic [1:0] l, input logic pe, po, msb, inv, input logic [7:0] d);
    logic [11:0] got, expf;
    int len, n, tx0, rx0;
    loop = 1'b1;
    set_cfg(l, pe, po, 1'b0, inv, msb);
    len = 5 + int'(l);
    n = len + 2 + int'(pe);
    expf = exp_frame(d, len, pe, po, msb);
    check(txd == ~inv, "R8 idle level", int'(txd), int'(~inv));
    tx0 = n_tx; rx0 = n_rx;
    write_tx(d);
    capture(n, got);
    check(got == expf, "R1 R2 R9 tx frame bits", int'(got), int'(expf));
    cyc(24);
    check(rx_valid == 1'b1, "R13 rx_valid after loopback", int'(rx_valid), 1);
    check(rx_data == (d & (8'hFF >> (8 - len))), "R1 R9 rx data", int'(rx_data),
          int'(d & (8'hFF >> (8 - len))));
    check(err_parity == 1'b0, "R4 no parity error", int'(err_parity), 0);
    check(n_tx == tx0 + 1 && n_rx == rx0 + 1, "R13 one pulse each", n_tx - tx0 + 16 * (n_rx - rx0), 17);
    read_rx();
    check(rx_valid == 1'b0, "R13 rx_rd clears valid", int'(rx_valid), 0);
  endtask

  task automatic t_busy_stop(input logic s2);
    int exp_len;
    loop = 1'b0;
    set_cfg(2'd3, 1'b0, 1'b0, s2, 1'b0, 1'b0);
    exp_len = 16 * (10 + int'(s2));
    write_tx(8'h3C);
    check(tx_busy == 1'b1, "R7 busy after write", int'(tx_busy), 1);
    cyc(2);
    check(tx_busy == 1'b0, "R7 busy clears on load", int'(tx_busy), 0);
    write_tx(8'hC3);
    cyc(60);
    check(tx_busy == 1'b1, "R7 busy while waiting", int'(tx_busy), 1);
    cyc(2 * exp_len);
    check(tx_busy == 1'b0, "R7 busy after second load", int'(tx_busy), 0);
    check(tx_last - tx_prev == exp_len, "R3 frame period with stop bits", tx_last - tx_prev, exp_len);
  endtask

  task automatic t_rx_errors();
    logic [11:0] f;
    loop = 1'b0;
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    f = exp_frame(8'h5A, 8, 1'b1, 1'b0, 1'b0);
    f[9] = ~f[9];
    drive_rx(f, 11);
    cyc(8);
    check(err_parity == 1'b1, "R4 parity error set", int'(err_parity), 1);
    check(rx_data == 8'h5A, "R4 data still delivered", int'(rx_data), 8'h5A);
    check(err_frame == 1'b0, "R5 no framing error", int'(err_frame), 0);
    clear_err();
    read_rx();
    check(err_parity == 1'b0, "R13 err_clr clears parity", int'(err_parity), 0);
    f = exp_frame(8'h81, 8, 1'b1, 1'b0, 1'b0);
    f[10] = 1'b0;
    drive_rx(f, 11);
    cyc(8);
    check(err_frame == 1'b1, "R5 framing error set", int'(err_frame), 1);
    cyc(20);
    check(err_frame == 1'b1, "R13 flag sticky", int'(err_frame), 1);
    clear_err();
    read_rx();
  endtask

  task automatic t_overrun();
    logic [11:0] f;
    int rx0;
    loop = 1'b0;
    set_cfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rx0 = n_rx;
    f = exp_frame(8'h11, 7, 1'b0, 1'b0, 1'b0);
    drive_rx(f, 9);
    f = exp_frame(8'h6E, 7, 1'b0, 1'b0, 1'b0);
    drive_rx(f, 9);
    cyc(8);
    check(n_rx - rx0 == 2, "R3 back-to-back after one stop", n_rx - rx0, 2);
    check(err_frame == 1'b0, "R3 single stop accepted", int'(err_frame), 0);
    check(err_overrun == 1'b1, "R6 overrun set", int'(err_overrun), 1);
    check(rx_data == 8'h6E, "R6 newest character kept", int'(rx_data), 8'h6E);
  endtask

  task automatic t_glitch();
    int rx0;
    loop = 1'b0;
    read_rx();
    rx0 = n_rx;
    drv = invert; cyc(3); drv = ~invert;
    cyc(40);
    check(n_rx == rx0, "R12 short start rejected", n_rx - rx0, 0);
    check(rx_valid == 1'b0, "R12 nothing delivered", int'(rx_valid), 0);
  endtask

  task automatic t_baud();
    int low, w;
    loop = 1'b1;
    divisor = 16'd2;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    write_tx(8'hFF);
    w = 0;
    while (txd != 1'b0 && w < 400) begin cyc(1); w++; end
    low = 0;
    while (txd == 1'b0 && low < 400) begin low++; cyc(1); end
    check(low == 48, "R10 start bit length", low, 48);
    cyc(500);
    read_rx();
    divisor = 16'd0;
    cyc(10);
  endtask

  task automatic t_block();
    logic [11:0] f;
    loop = 1'b0;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    f = exp_frame(8'h42, 8, 1'b0, 1'b0, 1'b0);
    drive_rx(f, 10);
    cyc(8);
    blk_off = 2'b01;
    cyc(5);
    check(rx_valid == 1'b1 && err_overrun == 1'b1, "R11 one bit set keeps state",
          int'({rx_valid, err_overrun}), 3);
    blk_off = 2'b11;
    write_tx(8'h99);
    cyc(3);
    check(tx_busy == 1'b0, "R11 write ignored in reset", int'(tx_busy), 0);
    blk_off = 2'b00;
    cyc(2);
    check(rx_valid == 1'b0 && err_overrun == 1'b0, "R11 reset clears state",
          int'({rx_valid, err_overrun}), 0);
    check(txd == 1'b1, "R11 line idle after reset", int'(txd), 1);
  endtask

  initial begin
    cyc(5);
    rst = 1'b0;
    t_reset();
    t_frame(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
    t_frame(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
    t_frame(2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h2D);
    t_frame(2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 8'h53);
    t_frame(2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80);
    t_busy_stop(1'b1);
    t_busy_stop(1'b0);
    t_rx_errors();
    t_overrun();
    t_glitch();
    t_baud();
    t_overrun();
    t_block();
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0h expected %0h", cyc_n, 0);
      report();
      $finish;
    end
  end
endmodule